// File: doc/BRIEF.md
# Decimal Scaled-Integer Arithmetic Unit

This unit adds, subtracts or multiplies two signed decimal numbers held as scaled integers. Each operand word carries a metadata byte on top and a packed-BCD magnitude below it. The metadata byte holds a sign, a two-bit encoding tag and a five-bit count of decimal places E. The operand's value is the magnitude times ten to the power minus E. A two-bit select picks the operation. The result is packed in the same word layout and registered, one clock after the operands are presented.

Addition and subtraction run on signed-magnitude rules over a chain of BCD digit adders. Subtraction is carried out as a nines'-complement add, and a second adder re-complements the difference when a borrow shows that the second magnitude was the larger. Multiplication builds one BCD partial-product row per digit of the second operand and adds the rows up digit-wise. Operands must use BCD encoding. Results that do not fit, scale mismatches and the reserved select code are reported on three flags, and in each of these cases the result word is a canonical zero.

Top module: `bcd_scaled_alu`

## Requirements
- R1: The result and all three flags are registered. Inputs presented before a rising clock edge appear at the outputs after that edge. While rst is high at an edge, the result becomes the canonical zero (metadata byte 0x60, all magnitude digits 0) and all flags clear.
- R2: Word layout: bit OPW-1 is the sign (1 = negative), bits OPW-2:OPW-3 are the encoding (11 = BCD), bits OPW-4:4*DIGITS are E, and the low 4*DIGITS bits hold BCD digits with the least significant digit in bits 3:0. For op_sel 0 (add) with operand signs equal, the result magnitude is the sum of the magnitudes, the sign is the common sign and E is the operands' E.
- R3: op_sel 1 (subtract) inverts the sign of the second operand and then follows the add rules. When the effective signs differ, the magnitude is the absolute difference and the sign is that of the operand with the larger magnitude.
- R4: A result whose magnitude is zero always carries a positive sign.
- R5: For op_sel 2 (multiply), the magnitude is the decimal product, the sign is the XOR of the operand signs, and E is the sum of the operand E values. The operands' E values need not match.
- R6: overflow rises when an add or subtract carries out of the top digit, when a product has a nonzero digit above the low DIGITS digits, or when the result E exceeds SCALE_MAX (14). The result is then the canonical zero.
- R7: For add or subtract with unequal operand E values, scale_mismatch rises and the result is the canonical zero.
- R8: op_sel 3 is reserved. It raises invalid_op and yields the canonical zero.
- R9: An operand whose encoding field is not 11 raises invalid_op and yields the canonical zero.
- R10: At most one flag is high. invalid_op takes precedence over scale_mismatch, which takes precedence over overflow.
- R11: The result's encoding field is always 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 8+4*DIGITS | First operand word |
| opb | input | 8+4*DIGITS | Second operand word |
| op_sel | input | 2 | 0 add, 1 subtract, 2 multiply, 3 reserved |
| result | output | 8+4*DIGITS | Registered result word |
| overflow | output | 1 | Result does not fit in digits or scale |
| scale_mismatch | output | 1 | Add or subtract with unequal scales |
| invalid_op | output | 1 | Reserved select or non-BCD operand |

## Verification
The bench builds the unit with DIGITS = 2 and the default SCALE_MAX of 14. This keeps each magnitude in the range 0 to 99, so every pair of magnitudes can be driven through add, subtract and multiply. The sweep varies signs and scales with the operand values. It therefore reaches carries out of the top digit, borrow recovery, zero results of every sign combination, product overflow and scale sums above 14. Directed vectors then cover the flag precedence, non-BCD encodings and the reserved select code.

// File: rtl/bcd_alu_pkg.sv
`timescale 1ns/1ps
package bcd_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef struct packed {
    logic       neg;
    logic [1:0] enc;
    logic [4:0] scale;
  } meta_t;

  localparam logic [1:0] ENC_BCD = 2'b11;
  localparam int META_W = 8;
endpackage

// File: rtl/bcd_digit_add.sv
`timescale 1ns/1ps
module bcd_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] s,
  output logic       cout
);
  logic [4:0] bin;
  logic [4:0] adj;

  always_comb begin
    bin  = {1'b0, a} + {1'b0, b} + {4'd0, cin};
    cout = (bin > 5'd9);
    adj  = cout ? (bin + 5'd6) : bin;
    s    = adj[3:0];
  end

  // R2: valid input digits always give a valid output digit
  always_comb begin
    if (a <= 4'd9 && b <= 4'd9) begin
      a_r2_digit_ok: assert (s <= 4'd9);
    end
  end
endmodule

// File: rtl/bcd_addsub.sv
`timescale 1ns/1ps
module bcd_addsub #(
  parameter int ND = 8
) (
  input  logic [4*ND-1:0] a,
  input  logic [4*ND-1:0] b,
  input  logic            sub,
  output logic [4*ND-1:0] sum,
  output logic            carry
);
  localparam int W = 4*ND;

  logic [W-1:0] b_eff;
  logic [ND:0]  c;

  assign c[0] = sub;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    assign b_eff[4*i +: 4] = sub ? (4'd9 - b[4*i +: 4]) : b[4*i +: 4];
    bcd_digit_add u_dig (
      .a   (a[4*i +: 4]),
      .b   (b_eff[4*i +: 4]),
      .cin (c[i]),
      .s   (sum[4*i +: 4]),
      .cout(c[i+1])
    );
  end

  assign carry = c[ND];
endmodule

// File: rtl/bcd_mult.sv
`timescale 1ns/1ps
module bcd_mult #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0]   a,
  input  logic [4*DIGITS-1:0]   b,
  output logic [8*DIGITS-1:0]   prod
);
  localparam int W2 = 2*DIGITS;
  localparam int NW = 4*W2;

  function automatic logic [7:0] dprod(input logic [3:0] x, input logic [3:0] y);
    logic [6:0] p;
    logic [6:0] hi;
    logic [6:0] lo;
    p  = {3'd0, x} * {3'd0, y};
    hi = p / 7'd10;
    lo = p - hi * 7'd10;
    return {hi[3:0], lo[3:0]};
  endfunction

  logic [NW-1:0]     acc [DIGITS+1];
  logic [2*DIGITS-1:0] cy;

  assign acc[0] = '0;

  for (genvar j = 0; j < DIGITS; j++) begin : g_row
    logic [NW-1:0] lo_v;
    logic [NW-1:0] hi_v;
    logic [NW-1:0] row_v;
    logic [NW-1:0] shf_v;

    always_comb begin
      logic [7:0] pp;
      lo_v = '0;
      hi_v = '0;
      for (int i = 0; i < DIGITS; i++) begin
        pp = dprod(a[4*i +: 4], b[4*j +: 4]);
        lo_v[4*i +: 4]     = pp[3:0];
        hi_v[4*(i+1) +: 4] = pp[7:4];
      end
    end

    bcd_addsub #(.ND(W2)) u_row (
      .a    (lo_v),
      .b    (hi_v),
      .sub  (1'b0),
      .sum  (row_v),
      .carry(cy[2*j])
    );

    assign shf_v = row_v << (4*j);

    bcd_addsub #(.ND(W2)) u_acc (
      .a    (acc[j]),
      .b    (shf_v),
      .sub  (1'b0),
      .sum  (acc[j+1]),
      .carry(cy[2*j+1])
    );
  end

  assign prod = acc[DIGITS];

  // R5: a full-width product never carries out of the double-width accumulator
  always_comb begin
    a_r5_rows_fit: assert (cy == '0);
  end
endmodule

// File: rtl/bcd_scaled_alu.sv
`timescale 1ns/1ps
module bcd_scaled_alu
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS    = 8,
  parameter int SCALE_MAX = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [8+4*DIGITS-1:0] opa,
  input  logic [8+4*DIGITS-1:0] opb,
  input  logic [1:0]            op_sel,
  output logic [8+4*DIGITS-1:0] result,
  output logic                  overflow,
  output logic                  scale_mismatch,
  output logic                  invalid_op
);
  localparam int MAG_W = 4*DIGITS;
  localparam int OPW   = MAG_W + META_W;
  localparam logic [5:0] SMAX6 = 6'(SCALE_MAX);
  localparam logic [OPW-1:0] CANON = {1'b0, ENC_BCD, 5'd0, {MAG_W{1'b0}}};

  meta_t          ma, mb;
  logic [MAG_W-1:0] xa, xb;
  op_e            op;

  assign ma = opa[OPW-1:MAG_W];
  assign mb = opb[OPW-1:MAG_W];
  assign xa = opa[MAG_W-1:0];
  assign xb = opb[MAG_W-1:0];
  assign op = op_e'(op_sel);

  // effective signs for the signed-magnitude adder
  logic sb_eff, diff;
  assign sb_eff = mb.neg ^ (op == OP_SUB);
  assign diff   = ma.neg ^ sb_eff;

  logic [MAG_W-1:0]   raw, negd;
  logic               raw_c, neg_c;
  logic [2*MAG_W-1:0] prod;

  bcd_addsub #(.ND(DIGITS)) u_main (
    .a    (xa),
    .b    (xb),
    .sub  (diff),
    .sum  (raw),
    .carry(raw_c)
  );

  // ten's complement of the raw difference when a borrow occurred
  bcd_addsub #(.ND(DIGITS)) u_recomp (
    .a    ({MAG_W{1'b0}}),
    .b    (raw),
    .sub  (1'b1),
    .sum  (negd),
    .carry(neg_c)
  );

  bcd_mult #(.DIGITS(DIGITS)) u_mul (
    .a   (xa),
    .b   (xb),
    .prod(prod)
  );

  logic             inv_n, mism_n, ovf_n, fit_ovf;
  logic [MAG_W-1:0] mag;
  logic             sgn;
  logic [5:0]       scl;
  logic [OPW-1:0]   nxt;

  always_comb begin
    inv_n  = (op == OP_RSV) || (ma.enc != ENC_BCD) || (mb.enc != ENC_BCD);
    mism_n = !inv_n && (op != OP_MUL) && (ma.scale != mb.scale);
    if (op == OP_MUL) begin
      mag     = prod[MAG_W-1:0];
      sgn     = ma.neg ^ mb.neg;
      scl     = {1'b0, ma.scale} + {1'b0, mb.scale};
      fit_ovf = |prod[2*MAG_W-1:MAG_W];
    end else begin
      scl = {1'b0, ma.scale};
      if (!diff) begin
        mag     = raw;
        sgn     = ma.neg;
        fit_ovf = raw_c;
      end else if (raw_c) begin
        mag     = raw;
        sgn     = ma.neg;
        fit_ovf = 1'b0;
      end else begin
        mag     = negd;
        sgn     = sb_eff;
        fit_ovf = 1'b0;
      end
    end
    ovf_n = !inv_n && !mism_n && (fit_ovf || (scl > SMAX6));
    if (inv_n || mism_n || ovf_n) nxt = CANON;
    else                          nxt = {sgn & (|mag), ENC_BCD, scl[4:0], mag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result         <= CANON;
      overflow       <= 1'b0;
      scale_mismatch <= 1'b0;
      invalid_op     <= 1'b0;
    end else begin
      result         <= nxt;
      overflow       <= ovf_n;
      scale_mismatch <= mism_n;
      invalid_op     <= inv_n;
    end
  end

  // R3: a borrowed difference is nonzero, so its re-complement never carries
  always_comb begin
    if (!rst && diff && !raw_c && (op != OP_MUL)) begin
      a_r3_recomp_no_carry: assert (!neg_c);
    end
  end

  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow, scale_mismatch, invalid_op}));

  a_r8_reserved_op: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd3) |=> invalid_op);

  a_r7_mul_any_scale: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd2) |=> !scale_mismatch);

  a_r4_zero_positive: assert property (@(posedge clk) disable iff (rst)
    (result[MAG_W-1:0] == '0) |-> !result[OPW-1]);

  a_r6_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (overflow || scale_mismatch || invalid_op) |-> (result == CANON));

  a_r11_bcd_tag: assert property (@(posedge clk) disable iff (rst)
    result[OPW-2 -: 2] == ENC_BCD);
endmodule

// File: tb/sim_bcd_scaled_alu.sv
`timescale 1ns/1ps
module sim_bcd_scaled_alu;
  localparam int BD   = 2;
  localparam int MW   = 4*BD;
  localparam int OW   = MW + 8;
  localparam int MAXV = 99;

  logic          clk = 1'b0;
  logic          rst;
  logic [OW-1:0] opa, opb, result;
  logic [1:0]    op_sel;
  logic          overflow, scale_mismatch, invalid_op;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bcd_scaled_alu #(.DIGITS(BD), .SCALE_MAX(14)) u0 (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sel(op_sel),
    .result(result), .overflow(overflow),
    .scale_mismatch(scale_mismatch), .invalid_op(invalid_op)
  );

  function automatic logic [MW-1:0] to_bcd(input int v);
    logic [MW-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < BD; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] got, input logic [2:0] gf,
                       input logic [OW-1:0] exp, input logic [2:0] ef);
    total++;
    if (got !== exp || gf !== ef) begin
      bad++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b", tag, got, gf, exp, ef);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(input logic [1:0] op, input logic [7:0] ma, input int a,
                       input logic [7:0] mb, input int b, input string tag);
    int va, vb, r, mag, sc;
    logic sa, sb, sbe, sgn, inv, mm, ov;
    logic [OW-1:0] ew;
    string t;
    opa = {ma, to_bcd(a)};
    opb = {mb, to_bcd(b)};
    op_sel = op;
    @(negedge clk);
    sa  = ma[7];
    sb  = mb[7];
    inv = (op == 2'd3) || (ma[6:5] != 2'b11) || (mb[6:5] != 2'b11);
    mm  = !inv && (op != 2'd2) && (ma[4:0] != mb[4:0]);
    if (op == 2'd2) begin
      mag = a * b;
      sc  = int'(ma[4:0]) + int'(mb[4:0]);
      sgn = sa ^ sb;
    end else begin
      sbe = sb ^ (op == 2'd1);
      va  = sa ? -a : a;
      vb  = sbe ? -b : b;
      r   = va + vb;
      mag = (r < 0) ? -r : r;
      sgn = (r < 0);
      sc  = int'(ma[4:0]);
    end
    ov = !inv && !mm && ((mag > MAXV) || (sc > 14));
    if (mag == 0) sgn = 1'b0;
    if (inv || mm || ov) ew = {8'h60, {MW{1'b0}}};
    else                 ew = {sgn, 2'b11, 5'(sc), to_bcd(mag)};
    if (tag != "")            t = tag;
    else if (inv)             t = (op == 2'd3) ? "R8" : "R9";
    else if (mm)              t = "R7";
    else if (ov)              t = "R6";
    else if (op == 2'd2)      t = "R5";
    else if (mag == 0)        t = "R4";
    else if (va * vb >= 0)    t = "R2";
    else                      t = "R3";
    check(t, result, {overflow, scale_mismatch, invalid_op}, ew, {ov, mm, inv});
    check("R11", {6'd0, result[OW-2 -: 2]}, 3'b000, {6'd0, 2'b11}, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst    = 1'b1;
    opa    = {8'h6A, to_bcd(77)};
    opb    = {8'hE3, to_bcd(12)};
    op_sel = 2'd2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", result, {overflow, scale_mismatch, invalid_op}, {8'h60, {MW{1'b0}}}, 3'b000);
    rst = 1'b0;

    // add / subtract sweep over every magnitude pair
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        logic [4:0] e;
        e = 5'((a + b) % 16);
        apply(2'((a + b) % 2), {1'((a / 3) % 2), 2'b11, e}, a,
              {1'((b / 5) % 2), 2'b11, e}, b, "");
      end
    end

    // multiply sweep over every magnitude pair
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        apply(2'd2, {1'((a / 7) % 2), 2'b11, 5'(a % 8)}, a,
              {1'(b % 2), 2'b11, 5'(b % 9)}, b, "");
      end
    end

    // directed corners
    apply(2'd0, 8'h62, 12, 8'h63, 5, "R7");
    apply(2'd1, 8'hE4, 40, 8'h61, 5, "R7");
    apply(2'd2, 8'h62, 12, 8'h63, 5, "R7");
    apply(2'd3, 8'h60, 1, 8'h60, 1, "R8");
    apply(2'd0, 8'h42, 3, 8'h62, 3, "R9");
    apply(2'd1, 8'h62, 3, 8'h02, 3, "R9");
    apply(2'd2, 8'h22, 3, 8'h62, 3, "R9");
    apply(2'd3, 8'h61, 50, 8'h64, 60, "R10");
    apply(2'd0, 8'h61, 99, 8'h62, 99, "R10");
    apply(2'd0, 8'h41, 99, 8'h62, 99, "R10");
    apply(2'd2, 8'h6E, 2, 8'h61, 3, "R6");
    apply(2'd2, 8'h60, 10, 8'h60, 10, "R6");
    apply(2'd0, 8'h60, 99, 8'h60, 1, "R6");
    apply(2'd1, 8'hE0, 50, 8'h60, 50, "R6");
    apply(2'd0, 8'h6F, 1, 8'h6F, 1, "R6");
    apply(2'd1, 8'hE3, 7, 8'hE3, 7, "R4");
    apply(2'd2, 8'hE0, 0, 8'h60, 5, "R4");
    apply(2'd1, 8'h60, 3, 8'h60, 9, "R3");
    apply(2'd0, 8'hE8, 42, 8'h68, 50, "R3");
    apply(2'd2, 8'hE7, 9, 8'hE7, 11, "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule